// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM organised as one mebi-word of eight bits. The host offers one word at a time: a read or a write with a 20-bit address. The sequencer turns each request into properly timed strobes. These are an active-low primary select, an active-high secondary select, an active-low output enable and an active-low write strobe. Because the data bus is split into an outbound word, an inbound word and a drive enable, the pad ring can build the bidirectional pin from them.

Every analogue timing limit of the RAM is given in nanoseconds as a parameter. Each limit is turned into a whole number of clock cycles by ceiling division by the clock period, and every phase lasts at least one cycle. At the default 5 ns period this gives a 14-cycle read strobe, a 12-cycle write strobe, a 2-cycle write recovery and a 5-cycle bus turnaround after every read. A new request is taken only while the sequencer is idle. Read data comes back in a register, flagged by a one-cycle valid pulse.

Top module: `sram_seq`

## Requirements
- R1: Out of reset and while idle, the sequencer holds cs1_n=1, cs2=0, oe_n=1, we_n=1 and dq_oe=0, with req_ready=1.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 0 until the operation and its recovery are complete. A request offered while req_ready is 0 has no effect on the memory.
- R3: A read holds cs1_n=0, cs2=1, oe_n=0 and we_n=1 with a stable address for exactly ceil(max(tRC,tAA,tOE)/period) cycles (14 at 70/70/35 ns and 5 ns).
- R4: The bus value on the last read-strobe cycle is captured into rd_data. rd_valid is then 1 for exactly one cycle, once per read, in request order.
- R5: A write holds cs1_n=0, cs2=1, we_n=0 and oe_n=1 for exactly ceil(max(tWP,tCW,tDW)/period) cycles (12 at 50/60/25 ns). During that time the address and dq_out are stable and dq_oe=1.
- R6: When the write strobe and both selects release, dq_oe stays 1 for one more cycle with the same data and then drops. The accept-to-ready interval of a write is max(ceil(tWC/period), write strobe + 1) cycles (14).
- R7: After a read strobe ends, the sequencer waits ceil(tHZ/period) idle cycles (5 at 25 ns) before req_ready returns. The accept-to-ready interval of a read is therefore 19 cycles, and a following write never drives the bus while the RAM may still be driving it.
- R8: dq_oe is never 1 while oe_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | 8 | Captured read word |
| ram_addr | output | 20 | RAM address lines |
| ram_cs1_n | output | 1 | Primary select, active low |
| ram_cs2 | output | 1 | Secondary select, active high |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_dq_out | output | 8 | Data toward the RAM |
| ram_dq_oe | output | 1 | Enable of the outbound data driver |
| ram_dq_in | input | 8 | Data from the RAM |

## Verification
If the phase state or the cycle counter goes wrong, the fault appears at the strobe pins within the same access. A read strobe one cycle short makes the RAM model return corrupted data, and the scoreboard sees it at the next rd_valid. A write strobe of the wrong length, or a missing driver hold, is reported when the write strobe rises. If the turnaround is too short, the model sees its own floating output overlap the sequencer's driver on the first write after a read. A busy sequencer that accepts a stray request shows up as a wrong word when a protected address is read back later.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_TURN,
    PH_WRITE,
    PH_WREC
  } phase_e;

  // ceiling division of a limit in ns by the clock period, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // recovery after the write strobe: covers the rest of the write cycle, at least one hold cycle
  function automatic int unsigned wrec_len(input int unsigned wc_cyc, input int unsigned wp_cyc);
    return (wc_cyc > wp_cyc + 1) ? (wc_cyc - wp_cyc) : 1;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          capture,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          rvalid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= bus_in;
    end
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 20,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_AA_NS       = 70,
  parameter int unsigned T_OE_NS       = 35,
  parameter int unsigned T_WC_NS       = 70,
  parameter int unsigned T_WP_NS       = 50,
  parameter int unsigned T_CW_NS       = 60,
  parameter int unsigned T_DW_NS       = 25,
  parameter int unsigned T_HZ_NS       = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs1_n,
  output logic              ram_cs2,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  localparam int unsigned RD_CYC = umax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                        umax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)));
  localparam int unsigned WR_CYC = umax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                        umax(ns_to_cyc(T_CW_NS, CLK_PERIOD_NS),
                                             ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)));
  localparam int unsigned WREC_CYC = wrec_len(ns_to_cyc(T_WC_NS, CLK_PERIOD_NS), WR_CYC);
  localparam int unsigned TA_CYC   = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, WR_CYC), umax(WREC_CYC, TA_CYC));
  localparam int unsigned CW       = $clog2(MAX_CYC + 1);

  phase_e        phase;
  logic          tmr_last;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          drv_hold;

  // named events, used by the FSM and by the assertions
  wire accept    = req_valid && (phase == PH_IDLE);
  wire read_end  = (phase == PH_READ)  && tmr_last;
  wire write_end = (phase == PH_WRITE) && tmr_last;
  wire turn_end  = (phase == PH_TURN)  && tmr_last;
  wire wrec_end  = (phase == PH_WREC)  && tmr_last;

  always_comb begin
    tmr_load = accept || read_end || write_end;
    tmr_val  = '0;
    if (accept)         tmr_val = req_write ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);
    else if (read_end)  tmr_val = CW'(TA_CYC - 1);
    else if (write_end) tmr_val = CW'(WREC_CYC - 1);
  end

  sram_phase_timer #(.W(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      drv_hold <= 1'b0;
    end else begin
      drv_hold <= write_end;
      unique case (phase)
        PH_IDLE:  if (accept)    phase <= req_write ? PH_WRITE : PH_READ;
        PH_READ:  if (read_end)  phase <= PH_TURN;
        PH_TURN:  if (turn_end)  phase <= PH_IDLE;
        PH_WRITE: if (write_end) phase <= PH_WREC;
        PH_WREC:  if (wrec_end)  phase <= PH_IDLE;
        default:                 phase <= PH_IDLE;
      endcase
    end
  end

  sram_dq_path #(.AW(ADDR_W), .DW(DATA_W)) u_dq (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (accept),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .capture  (read_end),
    .bus_in   (ram_dq_in),
    .addr_q   (ram_addr),
    .wdata_q  (ram_dq_out),
    .rdata_q  (rd_data),
    .rvalid_q (rd_valid)
  );

  wire selected = (phase == PH_READ) || (phase == PH_WRITE);

  assign req_ready = (phase == PH_IDLE);
  assign ram_cs1_n = !selected;
  assign ram_cs2   = selected;
  assign ram_oe_n  = (phase != PH_READ);
  assign ram_we_n  = (phase != PH_WRITE);
  assign ram_dq_oe = (phase == PH_WRITE) || drv_hold;

  // ---------------- assertions ----------------
  logic [CW:0] we_low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_len <= '0;
    else if (!ram_we_n) we_low_len <= we_low_len + 1'b1;
    else                we_low_len <= '0;
  end

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_oe_n && ram_dq_oe));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n && $past(!ram_we_n)) |-> $stable(ram_addr) && $stable(ram_dq_out));

  assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_low_len >= (CW+1)'(WR_CYC)));

  assert_hold_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_dq_oe && ram_we_n) |=> !ram_dq_oe);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_cs1_n && !ram_cs2 && ram_we_n && ram_oe_n));
endmodule

// File: tb/sram_seq_test.sv
module sram_seq_test;
  localparam int PER    = 5;
  localparam int RD_EXP = (70 + PER - 1) / PER;            // R3: 14
  localparam int WR_EXP = (60 + PER - 1) / PER;            // R5: 12 (largest of 50/60/25)
  localparam int FLOAT  = (25 + PER - 1) / PER;            // R7: 5
  localparam int RD_LAT = RD_EXP + FLOAT;                  // 19
  localparam int WR_LAT = ((70 + PER - 1) / PER > WR_EXP + 1) ? (70 + PER - 1) / PER : WR_EXP + 1; // 14
  localparam logic [19:0] GUARD = 20'h00042;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, ram_cs1_n, ram_cs2, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [7:0] rd_data, ram_dq_out;
  logic [7:0] model_dq = 8'h00;
  logic [19:0] ram_addr;

  always #(PER * 500ps) clk = ~clk;

  sram_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .ram_addr(ram_addr),
    .ram_cs1_n(ram_cs1_n), .ram_cs2(ram_cs2), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(model_dq));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------- RAM model ----------
  logic [7:0] mem [int];
  logic [7:0] ref_mem [int];
  function automatic logic [7:0] mem_at(input logic [19:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  int rsel_cyc = 0, wsel_cyc = 0, float_cnt = 0;
  bit hold_pending = 0;
  logic [19:0] raddr, waddr;
  logic [7:0]  wdat;

  always @(negedge clk) if (rst_n) begin
    automatic bit rsel = !ram_cs1_n && ram_cs2 && !ram_oe_n && ram_we_n;
    automatic bit wsel = !ram_cs1_n && ram_cs2 && !ram_we_n;
    if (ram_dq_oe && (rsel || float_cnt > 0)) chk(0, "R7/R8 bus contention", float_cnt, 0);
    if (rsel) begin
      if (rsel_cyc == 0) raddr = ram_addr;
      else if (ram_addr != raddr) chk(0, "R3 address moved", int'(ram_addr), int'(raddr));
      rsel_cyc++;
    end else if (rsel_cyc != 0) begin
      chk(rsel_cyc == RD_EXP, "R3 read strobe length", rsel_cyc, RD_EXP);
      rsel_cyc = 0;
      float_cnt = FLOAT;
    end else if (float_cnt > 0) float_cnt--;
    if (wsel) begin
      if (wsel_cyc == 0) waddr = ram_addr;
      else if (ram_addr != waddr) chk(0, "R5 address moved", int'(ram_addr), int'(waddr));
      if (!ram_dq_oe || !ram_oe_n) chk(0, "R5 driver/oe during write", ram_dq_oe, 1);
      if (wsel_cyc != 0 && ram_dq_out != wdat) chk(0, "R5 data moved", ram_dq_out, wdat);
      wdat = ram_dq_out;
      wsel_cyc++;
    end else if (wsel_cyc != 0) begin
      chk(wsel_cyc == WR_EXP, "R5 write strobe length", wsel_cyc, WR_EXP);
      mem[int'(waddr)] = wdat;
      chk(ram_dq_oe && ram_dq_out == wdat, "R6 hold cycle", ram_dq_oe, 1);
      hold_pending = 1;
      wsel_cyc = 0;
    end else if (hold_pending) begin
      chk(!ram_dq_oe, "R6 release", ram_dq_oe, 0);
      hold_pending = 0;
    end
    model_dq = (rsel && rsel_cyc >= RD_EXP) ? mem_at(ram_addr) : ~mem_at(ram_addr);
  end

  // ---------- scoreboard ----------
  logic [7:0] exp_q [$];
  bit prev_rv = 0;
  always @(negedge clk) if (rst_n) begin
    if (rd_valid) begin
      chk(!prev_rv, "R4 pulse width", 2, 1);
      if (exp_q.size() == 0) chk(0, "R4 unexpected rd_valid", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk(rd_data == e, "R4 read data", rd_data, e);
      end
    end
    prev_rv = rd_valid;
  end

  // ---------- driver ----------
  task automatic issue(input bit wr, input logic [19:0] a, input logic [7:0] d, input bit hog);
    int lat = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) ref_mem[int'(a)] = d;
    else exp_q.push_back(ref_mem[int'(a)]);
    @(negedge clk);
    req_valid = hog;
    if (hog) begin req_write = 1; req_addr = GUARD; req_wdata = 8'hC3; end
    while (!req_ready) begin lat++; @(negedge clk); end
    req_valid = 0;
    if (wr) chk(lat == WR_LAT, "R6 write occupancy", lat, WR_LAT);
    else    chk(lat == RD_LAT, "R7 read occupancy", lat, RD_LAT);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual hung expected done");
    summary();
    $finish;
  end

  logic [19:0] al [24];
  initial begin
    repeat (3) @(negedge clk);
    chk(ram_cs1_n && !ram_cs2 && ram_oe_n && ram_we_n && !ram_dq_oe, "R1 reset strobes", 0, 1);
    chk(req_ready && !rd_valid, "R1 reset ready", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && ram_cs1_n && !ram_cs2, "R1 idle after reset", req_ready, 1);
    issue(1, GUARD, 8'h3C, 0);
    issue(1, 20'h00000, 8'h5A, 0);
    issue(1, 20'hFFFFF, 8'hA5, 0);
    for (int i = 0; i < 24; i++) begin
      al[i] = 20'h80000 | 20'($urandom_range(0, 20'h7FFFF));
      issue(1, al[i], 8'($urandom), 0);
    end
    issue(0, 20'h00000, 0, 0);
    issue(0, 20'hFFFFF, 0, 0);
    for (int i = 0; i < 24; i++) issue(0, al[i], 0, i[0]);   // R2: odd ones hog the request lines
    for (int i = 0; i < 8; i++) begin                       // R7: read then write back to back
      issue(0, al[i], 0, 0);
      issue(1, al[i], 8'($urandom), 0);
      issue(0, al[i], 0, 0);
    end
    issue(0, GUARD, 0, 0);                                   // R2: busy-time writes must not land
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
    chk(req_ready && ram_cs1_n && !ram_dq_oe, "R1 idle at end", req_ready, 1);
    summary();
    $finish;
  end
endmodule